// File: doc/BRIEF.md
# Monochrome Glyph Expansion Engine

This block executes a character-draw command for a framebuffer renderer. A command packet already sits in a word-addressed buffer outside the block. On a start pulse the engine reads the packet one word per cycle through a combinational index/data port. It first checks the command word. It then decodes the left and right pixel positions and the top line, and captures a foreground and a background colour. Finally it turns the 1-bit glyph bitmap carried in the packet into a stream of pixel writes, one pixel per clock.

Each glyph word holds two rows of up to 16 pixels, so a full character is 22 lines tall. The block also keeps a running dirty window, which a display refresh stage can use to limit its copy to the lines and columns that changed. Pixel depth is a build parameter. In 8-bit mode the colour word's low byte is written as it is. In 24-bit mode a three-level grey code is written to all three channels.

Top module: `glyph_expand`

## Requirements
- R1: After reset, pix_we_o, busy_o and done_o are low. The dirty window is empty: both low bounds are all ones (2047) and both high bounds are 0.
- R2: The first read is word index 0. The command runs only when that word equals 0x00000A21. Any other value ends the command with no pixel write and no change to the dirty window, and done_o still pulses.
- R3: Position words are at word indices 13 (left/top) and 14 (right). For a position word v: column = ((v >> 19) & 2047) mod 1280, and line = (((v - 63) mod 2^32) >> 3) & 1023, then taken mod 1024.
- R4: The foreground colour is word index 16 and the background colour is word index 29. In 8-bit mode the pixel value is bits [7:0] of the colour word. In 24-bit mode the pixel is a grey level g replicated as {g,g,g}: g is 0 when bits [23:16] are 0, 192 when they are 7, and 255 otherwise.
- R5: Glyph words are consumed at indices 4 to 11 and then 30 to 32; indices 12 to 29 are never used as glyph data. Each word gives two rows, bits [15:0] first and then bits [31:16]. Row r (0 to 21) is written on line top + r, with no wrap.
- R6: Within a row half, bit n drives column left + n. A set bit writes the foreground value and a clear bit writes the background value. Pixels are written one per cycle in ascending column order.
- R7: Row width is right - left, clamped to 16. A width of zero or less produces no pixel writes and leaves the dirty window unchanged.
- R8: When a command has a positive width, the dirty window's column bounds widen to include left and right. Its line bounds widen to include every line written.
- R9: busy_o is high from the cycle after start_i is taken until done_o, inclusive. done_o is a one-cycle pulse in the cycle after the last pixel write. start_i is ignored while busy_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin executing the packet in the buffer |
| pkt_idx_o | output | 6 | Packet word index being read |
| pkt_word_i | input | 32 | Packet word at pkt_idx_o, same cycle |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | Command finished (one-cycle pulse) |
| pix_we_o | output | 1 | Pixel write strobe |
| pix_x_o | output | 11 | Pixel column |
| pix_y_o | output | 11 | Pixel line |
| pix_data_o | output | PIX_W (24 or 8) | Pixel value |
| dirty_x_lo_o | output | 11 | Dirty window left bound |
| dirty_x_hi_o | output | 11 | Dirty window right bound |
| dirty_y_lo_o | output | 11 | Dirty window top bound |
| dirty_y_hi_o | output | 11 | Dirty window bottom bound |

## Verification
A wrong row or half counter shows on the first misplaced pixel. The line number or the data bit is wrong in the same cycle as the write, so the pixel-by-pixel comparison catches it within one row. A bad width or a bad decode latch changes how many pixels come out, which shows at the end of the command. A wrong dirty bound is visible one cycle after the write that should have widened it. It is checked after every command, so an error there persists across commands and shows in the next comparison.

// File: rtl/glyph_pkg.sv
package glyph_pkg;
  localparam int WORD_W = 32;
  localparam int IDX_W  = 6;

  localparam logic [WORD_W-1:0] CMD_CHAR = 32'h0000_0A21;

  localparam int IDX_CMD   = 0;
  localparam int IDX_POS_A = 13;
  localparam int IDX_POS_B = 14;
  localparam int IDX_FG    = 16;
  localparam int IDX_BG    = 29;

  localparam int X_LSB  = 19;
  localparam int Y_LSB  = 3;
  localparam int Y_BIAS = 63;

  localparam int GREY_MID_CODE = 7;
  localparam int GREY_MID      = 192;
  localparam int GREY_FULL     = 255;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CMD,
    ST_POS_A,
    ST_POS_B,
    ST_FG,
    ST_BG,
    ST_LOAD,
    ST_PIX,
    ST_DONE
  } glyph_state_e;
endpackage

// File: rtl/glyph_pos_decode.sv
module glyph_pos_decode #(
  parameter int WORD_W = 32,
  parameter int X_W    = 11,
  parameter int Y_W    = 10,
  parameter int X_SIZE = 1280,
  parameter int Y_SIZE = 1024
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [X_W-1:0]    x_o,
  output logic [Y_W-1:0]    y_o
);
  import glyph_pkg::*;

  logic [WORD_W-1:0] x_sh;
  logic [WORD_W-1:0] y_biased;
  logic [WORD_W-1:0] y_sh;
  logic [X_W-1:0]    x_raw;
  logic [Y_W-1:0]    y_raw;

  always_comb begin
    x_sh     = word_i >> X_LSB;
    y_biased = word_i - WORD_W'(Y_BIAS);
    y_sh     = y_biased >> Y_LSB;
    x_raw    = x_sh[X_W-1:0];
    y_raw    = y_sh[Y_W-1:0];
    x_o      = X_W'(int'(x_raw) % X_SIZE);
    y_o      = Y_W'(int'(y_raw) % Y_SIZE);
  end
endmodule

// File: rtl/glyph_colour_map.sv
module glyph_colour_map #(
  parameter int WORD_W = 32,
  parameter bit DEEP   = 1'b1,
  parameter int PIX_W  = DEEP ? 24 : 8
) (
  input  logic [WORD_W-1:0] word_i,
  output logic [PIX_W-1:0]  pix_o
);
  import glyph_pkg::*;

  generate
    if (DEEP) begin : g_grey
      logic [7:0] code;
      logic [7:0] level;
      always_comb begin
        code = word_i[23:16];
        if (code == 8'd0)                       level = 8'd0;
        else if (code == 8'(GREY_MID_CODE))     level = 8'(GREY_MID);
        else                                    level = 8'(GREY_FULL);
        pix_o = PIX_W'({3{level}});
      end
    end else begin : g_index
      always_comb pix_o = PIX_W'(word_i[7:0]);
    end
  endgenerate
endmodule

// File: rtl/glyph_row_seq.sv
module glyph_row_seq #(
  parameter int IDX_W      = 6,
  parameter int N_WORDS    = 11,
  parameter int SPLIT      = 8,
  parameter int FIRST_IDX  = 4,
  parameter int SECOND_IDX = 30,
  parameter int HALF_W     = 16,
  localparam int G_W       = $clog2(N_WORDS),
  localparam int C_W       = $clog2(HALF_W),
  localparam int N_W       = $clog2(HALF_W + 1),
  localparam int ROW_W     = G_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [N_W-1:0]   width_i,
  output logic [IDX_W-1:0] word_idx_o,
  output logic [ROW_W-1:0] row_o,
  output logic [C_W-1:0]   col_o,
  output logic             hi_half_o,
  output logic             end_word_o,
  output logic             last_o
);
  logic [G_W-1:0] g_q;
  logic           h_q;
  logic [C_W-1:0] n_q;
  logic           end_half;

  assign end_half = (N_W'(n_q) + N_W'(1)) == width_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      g_q <= '0;
      h_q <= 1'b0;
      n_q <= '0;
    end else if (clr_i) begin
      g_q <= '0;
      h_q <= 1'b0;
      n_q <= '0;
    end else if (adv_i) begin
      if (end_half) begin
        n_q <= '0;
        if (h_q) begin
          h_q <= 1'b0;
          g_q <= g_q + G_W'(1);
        end else begin
          h_q <= 1'b1;
        end
      end else begin
        n_q <= n_q + C_W'(1);
      end
    end
  end

  // two discontiguous glyph word ranges
  always_comb begin
    if (int'(g_q) < SPLIT) word_idx_o = IDX_W'(FIRST_IDX + int'(g_q));
    else                   word_idx_o = IDX_W'(SECOND_IDX + int'(g_q) - SPLIT);
  end

  assign row_o      = {g_q, h_q};
  assign col_o      = n_q;
  assign hi_half_o  = h_q;
  assign end_word_o = end_half && h_q;
  assign last_o     = end_half && h_q && (g_q == G_W'(N_WORDS - 1));
endmodule

// File: rtl/glyph_dirty.sv
module glyph_dirty #(
  parameter int X_W = 11,
  parameter int Y_W = 11
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           span_we_i,
  input  logic [X_W-1:0] xa_i,
  input  logic [X_W-1:0] xb_i,
  input  logic           pt_we_i,
  input  logic [Y_W-1:0] py_i,
  output logic [X_W-1:0] x_lo_o,
  output logic [X_W-1:0] x_hi_o,
  output logic [Y_W-1:0] y_lo_o,
  output logic [Y_W-1:0] y_hi_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      x_lo_o <= '1;
      x_hi_o <= '0;
      y_lo_o <= '1;
      y_hi_o <= '0;
    end else begin
      if (span_we_i) begin
        if (xa_i < x_lo_o) x_lo_o <= xa_i;
        if (xb_i > x_hi_o) x_hi_o <= xb_i;
      end
      if (pt_we_i) begin
        if (py_i < y_lo_o) y_lo_o <= py_i;
        if (py_i > y_hi_o) y_hi_o <= py_i;
      end
    end
  end
endmodule

// File: rtl/glyph_expand.sv
module glyph_expand #(
  parameter int  X_SIZE  = 1280,
  parameter int  Y_SIZE  = 1024,
  parameter int  X_W     = 11,
  parameter int  Y_W     = 10,
  parameter int  MAX_W   = 16,
  parameter int  N_WORDS = 11,
  parameter bit  DEEP    = 1'b1,
  localparam int PIX_W   = DEEP ? 24 : 8,
  localparam int PY_W    = Y_W + 1,
  localparam int N_W     = $clog2(MAX_W + 1),
  localparam int C_W     = $clog2(MAX_W),
  localparam int ROW_W   = $clog2(N_WORDS) + 1
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         start_i,
  output logic [glyph_pkg::IDX_W-1:0]  pkt_idx_o,
  input  logic [glyph_pkg::WORD_W-1:0] pkt_word_i,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         pix_we_o,
  output logic [X_W-1:0]               pix_x_o,
  output logic [PY_W-1:0]              pix_y_o,
  output logic [PIX_W-1:0]             pix_data_o,
  output logic [X_W-1:0]               dirty_x_lo_o,
  output logic [X_W-1:0]               dirty_x_hi_o,
  output logic [PY_W-1:0]              dirty_y_lo_o,
  output logic [PY_W-1:0]              dirty_y_hi_o
);
  import glyph_pkg::*;

  glyph_state_e st_q;

  logic [X_W-1:0]    x1_q, x2_q;
  logic [Y_W-1:0]    y1_q;
  logic [PIX_W-1:0]  fg_q, bg_q;
  logic [WORD_W-1:0] gword_q;
  logic [N_W-1:0]    width_q;

  logic [X_W-1:0]    dec_x;
  logic [Y_W-1:0]    dec_y;
  logic [PIX_W-1:0]  cmap;
  logic [N_W-1:0]    width_c;
  logic [IDX_W-1:0]  seq_idx;
  logic [ROW_W-1:0]  seq_row;
  logic [C_W-1:0]    seq_col;
  logic              seq_hi, seq_end_word, seq_last;
  logic [MAX_W-1:0]  half_bits;

  glyph_pos_decode #(
    .WORD_W(WORD_W), .X_W(X_W), .Y_W(Y_W), .X_SIZE(X_SIZE), .Y_SIZE(Y_SIZE)
  ) i_pos (
    .word_i(pkt_word_i), .x_o(dec_x), .y_o(dec_y)
  );

  glyph_colour_map #(
    .WORD_W(WORD_W), .DEEP(DEEP), .PIX_W(PIX_W)
  ) i_cmap (
    .word_i(pkt_word_i), .pix_o(cmap)
  );

  glyph_row_seq #(
    .IDX_W(IDX_W), .N_WORDS(N_WORDS), .SPLIT(8), .FIRST_IDX(4),
    .SECOND_IDX(30), .HALF_W(MAX_W)
  ) i_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .clr_i(st_q == ST_BG), .adv_i(st_q == ST_PIX), .width_i(width_q),
    .word_idx_o(seq_idx), .row_o(seq_row), .col_o(seq_col),
    .hi_half_o(seq_hi), .end_word_o(seq_end_word), .last_o(seq_last)
  );

  // signed span, clamped to one glyph row
  always_comb begin
    logic signed [X_W+1:0] diff;
    diff = $signed({2'b00, x2_q}) - $signed({2'b00, x1_q});
    if (diff <= 0)                       width_c = '0;
    else if (diff > (X_W+2)'(MAX_W))     width_c = N_W'(MAX_W);
    else                                 width_c = N_W'(diff);
  end

  always_comb begin
    unique case (st_q)
      ST_CMD:   pkt_idx_o = IDX_W'(IDX_CMD);
      ST_POS_A: pkt_idx_o = IDX_W'(IDX_POS_A);
      ST_POS_B: pkt_idx_o = IDX_W'(IDX_POS_B);
      ST_FG:    pkt_idx_o = IDX_W'(IDX_FG);
      ST_BG:    pkt_idx_o = IDX_W'(IDX_BG);
      ST_LOAD:  pkt_idx_o = seq_idx;
      default:  pkt_idx_o = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      x1_q    <= '0;
      x2_q    <= '0;
      y1_q    <= '0;
      fg_q    <= '0;
      bg_q    <= '0;
      gword_q <= '0;
      width_q <= '0;
    end else begin
      unique case (st_q)
        ST_IDLE:  if (start_i) st_q <= ST_CMD;
        ST_CMD:   st_q <= (pkt_word_i == CMD_CHAR) ? ST_POS_A : ST_DONE;
        ST_POS_A: begin
          x1_q <= dec_x;
          y1_q <= dec_y;
          st_q <= ST_POS_B;
        end
        ST_POS_B: begin
          x2_q <= dec_x;
          st_q <= ST_FG;
        end
        ST_FG: begin
          fg_q <= cmap;
          st_q <= ST_BG;
        end
        ST_BG: begin
          bg_q    <= cmap;
          width_q <= width_c;
          st_q    <= (width_c == '0) ? ST_DONE : ST_LOAD;
        end
        ST_LOAD: begin
          gword_q <= pkt_word_i;
          st_q    <= ST_PIX;
        end
        ST_PIX:   if (seq_end_word) st_q <= seq_last ? ST_DONE : ST_LOAD;
        ST_DONE:  st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  assign half_bits  = seq_hi ? gword_q[2*MAX_W-1:MAX_W] : gword_q[MAX_W-1:0];
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = (st_q == ST_DONE);
  assign pix_we_o   = (st_q == ST_PIX);
  assign pix_x_o    = x1_q + X_W'(seq_col);
  assign pix_y_o    = PY_W'(y1_q) + PY_W'(seq_row);
  assign pix_data_o = half_bits[seq_col] ? fg_q : bg_q;

  glyph_dirty #(
    .X_W(X_W), .Y_W(PY_W)
  ) i_dirty (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .span_we_i((st_q == ST_BG) && (width_c != '0)),
    .xa_i(x1_q), .xb_i(x2_q),
    .pt_we_i(pix_we_o), .py_i(pix_y_o),
    .x_lo_o(dirty_x_lo_o), .x_hi_o(dirty_x_hi_o),
    .y_lo_o(dirty_y_lo_o), .y_hi_o(dirty_y_hi_o)
  );
endmodule

// File: rtl/glyph_expand_chk.sv
module glyph_expand_chk #(
  parameter int X_W  = 11,
  parameter int PY_W = 11
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            busy_o,
  input logic            done_o,
  input logic            pix_we_o,
  input logic [X_W-1:0]  pix_x_o,
  input logic [PY_W-1:0] pix_y_o,
  input logic [PY_W-1:0] dirty_y_lo_o,
  input logic [PY_W-1:0] dirty_y_hi_o
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!pix_we_o && !done_o));

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  busy_end_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(done_o));

  // R6
  col_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_we_o && $past(pix_we_o) && (pix_y_o == $past(pix_y_o)))
      |-> (pix_x_o == $past(pix_x_o) + X_W'(1)));

  // R5
  row_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_we_o && $past(pix_we_o) && (pix_y_o != $past(pix_y_o)))
      |-> (pix_y_o == $past(pix_y_o) + PY_W'(1)));

  // R8
  dirty_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_we_o |=> ((dirty_y_lo_o <= $past(pix_y_o)) && (dirty_y_hi_o >= $past(pix_y_o))));
endmodule

bind glyph_expand glyph_expand_chk #(
  .X_W(X_W), .PY_W(PY_W)
) i_glyph_expand_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy_o(busy_o), .done_o(done_o),
  .pix_we_o(pix_we_o), .pix_x_o(pix_x_o), .pix_y_o(pix_y_o),
  .dirty_y_lo_o(dirty_y_lo_o), .dirty_y_hi_o(dirty_y_hi_o)
);

// File: tb/test_glyph_expand.sv
module test_glyph_expand;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] pkt [0:63];

  logic [5:0]  idx_a, idx_b;
  logic        busy_a, done_a, we_a, busy_b, done_b, we_b;
  logic [10:0] px_a, py_a, px_b, py_b;
  logic [23:0] pd_a;
  logic [7:0]  pd_b;
  logic [10:0] dxl, dxh, dyl, dyh, dxl_b, dxh_b, dyl_b, dyh_b;

  glyph_expand i_glyph_expand (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .pkt_idx_o(idx_a), .pkt_word_i(pkt[idx_a]),
    .busy_o(busy_a), .done_o(done_a),
    .pix_we_o(we_a), .pix_x_o(px_a), .pix_y_o(py_a), .pix_data_o(pd_a),
    .dirty_x_lo_o(dxl), .dirty_x_hi_o(dxh), .dirty_y_lo_o(dyl), .dirty_y_hi_o(dyh)
  );

  glyph_expand #(.DEEP(1'b0)) i_glyph_expand_8 (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start),
    .pkt_idx_o(idx_b), .pkt_word_i(pkt[idx_b]),
    .busy_o(busy_b), .done_o(done_b),
    .pix_we_o(we_b), .pix_x_o(px_b), .pix_y_o(py_b), .pix_data_o(pd_b),
    .dirty_x_lo_o(dxl_b), .dirty_x_hi_o(dxh_b), .dirty_y_lo_o(dyl_b), .dirty_y_hi_o(dyh_b)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int cx[$], cy[$], cd[$], cd8[$];
  int ex[$], ey[$], ed[$], ed8[$];
  int last_we_cyc, done_cyc;
  bit done_seen;
  int m_xlo = 2047, m_xhi = 0, m_ylo = 2047, m_yhi = 0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (we_a) begin
        cx.push_back(int'(px_a)); cy.push_back(int'(py_a)); cd.push_back(int'(pd_a));
        last_we_cyc = cyc;
      end
      if (we_b) cd8.push_back(int'(pd_b));
      if (done_a) begin done_seen = 1'b1; done_cyc = cyc; end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int grey(input logic [31:0] w);
    if (w[23:16] == 8'd0) return 0;
    if (w[23:16] == 8'd7) return 192 * 65793;
    return 255 * 65793;
  endfunction

  function automatic logic [31:0] pos(input int x, input int line);
    return (32'(x) << 19) | ((32'(line) << 3) + 32'd63);
  endfunction

  task automatic build_expect();
    logic [31:0] v1, v2, t;
    int x1, y1, x2, w;
    ex.delete(); ey.delete(); ed.delete(); ed8.delete();
    if (pkt[0] != 32'h0000_0A21) return;
    v1 = pkt[13]; v2 = pkt[14];
    x1 = int'((v1 >> 19) & 32'd2047) % 1280;
    t  = v1 - 32'd63;
    y1 = int'((t >> 3) & 32'd1023) % 1024;
    x2 = int'((v2 >> 19) & 32'd2047) % 1280;
    w  = x2 - x1;
    if (w <= 0) return;
    if (w > 16) w = 16;
    if (x1 < m_xlo) m_xlo = x1;
    if (x2 > m_xhi) m_xhi = x2;
    for (int g = 0; g < 11; g++) begin
      int wi;
      wi = (g < 8) ? 4 + g : 30 + g - 8;
      for (int h = 0; h < 2; h++) begin
        logic [15:0] bits;
        bits = h ? pkt[wi][31:16] : pkt[wi][15:0];
        for (int n = 0; n < w; n++) begin
          int ln;
          ln = y1 + 2 * g + h;
          ex.push_back(x1 + n);
          ey.push_back(ln);
          ed.push_back(bits[n] ? grey(pkt[16]) : grey(pkt[29]));
          ed8.push_back(bits[n] ? int'(pkt[16][7:0]) : int'(pkt[29][7:0]));
          if (ln < m_ylo) m_ylo = ln;
          if (ln > m_yhi) m_yhi = ln;
        end
      end
    end
  endtask

  task automatic fill(input logic [31:0] cmd, input logic [31:0] v1, input logic [31:0] v2,
                      input logic [31:0] fg, input logic [31:0] bg);
    for (int i = 0; i < 64; i++) pkt[i] = $urandom;
    pkt[0] = cmd; pkt[13] = v1; pkt[14] = v2; pkt[16] = fg; pkt[29] = bg;
  endtask

  task automatic run(input string tag, input bit mid_start);
    int n;
    cx.delete(); cy.delete(); cd.delete(); cd8.delete();
    done_seen = 1'b0;
    build_expect();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy_a == 1'b1, "R9", {tag, " busy after start"}, int'(busy_a), 1);
    if (mid_start) begin
      repeat (8) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    for (int k = 0; k < 3000 && !done_seen; k++) @(negedge clk);
    chk(done_seen, "R9", {tag, " done seen"}, int'(done_seen), 1);
    repeat (3) @(negedge clk);
    chk(cx.size() == ex.size(), "R7", {tag, " pixel count"}, cx.size(), ex.size());
    chk(cd8.size() == ex.size(), "R7", {tag, " pixel count 8-bit"}, cd8.size(), ex.size());
    n = (cx.size() < ex.size()) ? cx.size() : ex.size();
    for (int i = 0; i < n; i++) begin
      chk(cx[i] == ex[i], "R6", {tag, " column"}, cx[i], ex[i]);
      chk(cy[i] == ey[i], "R5", {tag, " line"}, cy[i], ey[i]);
      chk(cd[i] == ed[i], "R4", {tag, " 24-bit data"}, cd[i], ed[i]);
      if (i < cd8.size()) chk(cd8[i] == ed8[i], "R4", {tag, " 8-bit data"}, cd8[i], ed8[i]);
    end
    if (cx.size() > 0)
      chk(done_cyc == last_we_cyc + 1, "R9", {tag, " done timing"}, done_cyc, last_we_cyc + 1);
    chk(int'(dxl) == m_xlo, "R8", {tag, " dirty x lo"}, int'(dxl), m_xlo);
    chk(int'(dxh) == m_xhi, "R8", {tag, " dirty x hi"}, int'(dxh), m_xhi);
    chk(int'(dyl) == m_ylo, "R8", {tag, " dirty y lo"}, int'(dyl), m_ylo);
    chk(int'(dyh) == m_yhi, "R8", {tag, " dirty y hi"}, int'(dyh), m_yhi);
    chk(busy_a == 1'b0, "R9", {tag, " idle after done"}, int'(busy_a), 0);
  endtask

  initial begin
    void'($urandom(32'd5150));
    for (int i = 0; i < 64; i++) pkt[i] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(we_a == 1'b0 && busy_a == 1'b0 && done_a == 1'b0, "R1", "outputs in reset", int'(busy_a), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(we_a == 1'b0 && busy_a == 1'b0 && done_a == 1'b0, "R1", "outputs after reset",
        int'({we_a, busy_a, done_a}), 0);
    chk(dxl == 11'h7FF && dyl == 11'h7FF, "R1", "dirty lo empty", int'(dxl), 2047);
    chk(dxh == 11'h0 && dyh == 11'h0, "R1", "dirty hi empty", int'(dxh), 0);

    // R2 bad command code: nothing written, window untouched
    fill(32'h0000_0A20, pos(100, 40), pos(116, 0), 32'h00050000, 32'h0);
    run("R2 bad code", 1'b0);

    // R6 basic 16-wide glyph
    fill(32'h0000_0A21, pos(100, 50), pos(116, 0), 32'h00050000, 32'h00000000);
    run("R6 basic", 1'b0);

    // R7 clamp to 16
    fill(32'h0000_0A21, pos(300, 200), pos(340, 0), 32'h00070011, 32'h00030022);
    run("R7 clamp", 1'b0);

    // R7 zero and negative width
    fill(32'h0000_0A21, pos(900, 900), pos(900, 0), 32'h00050000, 32'h0);
    run("R7 zero", 1'b0);
    fill(32'h0000_0A21, pos(905, 901), pos(899, 0), 32'h00050000, 32'h0);
    run("R7 negative", 1'b0);

    // R3 column wrap and line bias underflow
    fill(32'h0000_0A21, 32'd1290 << 19, pos(1300, 5), 32'h00000000, 32'h00070000);
    run("R3 wrap", 1'b0);

    // R4 grey levels and narrow row
    fill(32'h0000_0A21, pos(7, 3), pos(12, 0), 32'h0007_00AB, 32'h0080_00CD);
    run("R4 grey", 1'b0);

    // R9 start while busy ignored
    fill(32'h0000_0A21, pos(600, 400), pos(610, 0), 32'h00070000, 32'h00010000);
    run("R9 mid start", 1'b1);

    // R5 random commands
    for (int r = 0; r < 25; r++) begin
      int x1, dw, yl;
      logic [31:0] fg, bg;
      x1 = int'($urandom_range(1279, 0));
      dw = int'($urandom_range(22, 0)) - 2;
      yl = int'($urandom_range(1023, 0));
      fg = $urandom; bg = $urandom;
      case ($urandom_range(2, 0))
        0: fg[23:16] = 8'd0;
        1: fg[23:16] = 8'd7;
        default: ;
      endcase
      if ($urandom_range(1, 0) == 1) bg[23:16] = 8'd7;
      fill(32'h0000_0A21, pos(x1, yl), pos((x1 + dw + 1280) % 1280, 0), fg, bg);
      run("R5 random", 1'b0);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule